// File: doc/BRIEF.md
# Pipeline Stall and Interlock Controller

This block decides, every cycle, which parts of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) may advance. It watches the instruction-cache miss line, the data-cache miss line, and a load sitting in execute together with the source registers of the instruction in decode. From those it drives a program-counter hold, one enable per pipeline latch, and one bubble-insert strobe per latch. The caches answer a hit in one cycle and raise their miss line for as many cycles as a refill takes. While the line is up, the pipeline waits instead of running the cache on a faster clock.

A load-use dependency is caught in hardware, so software never needs a load delay slot. Every latch carries a valid tag, and an inserted bubble clears it. The tag reaching write-back feeds two 32-bit counters: one for real instructions retired and one for bubbles. Performance figures therefore exclude the stall filler.

Latch and strobe bit positions: bit 0 is the fetch/decode latch, bit 1 the decode/execute latch, bit 2 the execute/memory latch and bit 3 the memory/write-back latch. A latch with its enable at 1 loads a new value. If its bubble bit is also 1, that value is a bubble with a cleared valid tag; otherwise it is the tag of the stage before. A latch with its enable at 0 holds. Fetch always offers a valid instruction to latch 0.

Top module: `pipe_interlock_ctrl`

## Requirements
- R1: While reset is low and at reset release, both counters read 0 and all four stage valid tags read 0.
- R2: With the instruction-cache miss high and no data miss or load-use hazard, the PC is held, all enables are 1 and only bubble bit 0 is set, so decode receives a bubble while the later stages drain.
- R3: With the data-cache miss high, the PC is held, the enables read 4'b1000 and the bubbles read 4'b1000. Latches 0 to 2 keep their contents and write-back receives a bubble every such cycle, whatever the other inputs are.
- R4: A load-use hazard exists when execute holds a valid load and decode holds a valid instruction whose used source register equals the load's destination. It gives PC hold, enables 4'b1110 and bubbles 4'b0010. If the execute tag is a bubble, there is no hazard.
- R5: A destination register of 0 never forms a hazard, and a source whose use bit is 0 is never compared.
- R6: Priority runs data miss over load-use over instruction miss. Load-use combined with an instruction miss gives the load-use pattern, and decode keeps its instruction.
- R7: A latch that is held keeps its valid tag. A latch loading a bubble reads tag 0 after the edge. Otherwise the tag of the previous stage moves one stage per edge.
- R8: On every clock edge after reset, exactly one counter increments: the retired counter if the write-back tag is 1, otherwise the bubble counter.
- R9: Once the pipeline drains, the bubble counter has grown by exactly one for every stall cycle that inserted a bubble.
- R10: With no miss and no hazard, the PC is not held, all enables are 1 and no bubble bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| icacheMiss | input | 1 | Instruction cache is serving a miss |
| dcacheMiss | input | 1 | Data cache is serving a miss |
| exIsLoad | input | 1 | Instruction in execute is a load |
| exDestReg | input | REG_ADDR_W | Destination register of the execute instruction |
| idSrcRegs | input | NUM_SRC*REG_ADDR_W | Decode source registers, source k in bits [k*REG_ADDR_W +: REG_ADDR_W] |
| idSrcUsed | input | NUM_SRC | Per-source flag that decode actually reads that source |
| pcHold | output | 1 | Program counter must not advance |
| stageEn | output | 4 | Per-latch load enable |
| stageBubble | output | 4 | Per-latch bubble insert |
| idValid | output | 1 | Valid tag of the decode stage |
| exValid | output | 1 | Valid tag of the execute stage |
| memValid | output | 1 | Valid tag of the memory stage |
| wbValid | output | 1 | Valid tag of the write-back stage |
| retiredCount | output | CNT_W | Real instructions seen at write-back |
| bubbleCount | output | CNT_W | Bubbles seen at write-back |

## Verification
The load-use detector is swept exhaustively in a two-bit register configuration over every destination, both sources, both use bits and the load flag, with a full pipeline before each case. This separates true matches from register-zero matches, matches on an unused source and non-load instructions. Separate runs hold the instruction miss and the data miss for several cycles, and further runs join the data miss, then the instruction miss, with a load-use hazard. These tell apart bubble injection at decode, a freeze of the front three latches with bubbles into write-back, and the priority order. A case with a bubble already in execute shows that an invalid tag suppresses the interlock, and counter deltas after draining confirm one bubble per stall cycle and one count per edge.

// File: rtl/pipe_stall_pkg.sv
package pipe_stall_pkg;

  // number of inter-stage latches in a five-stage pipeline
  localparam int NUM_LATCH = 4;

  // latch positions, used where behaviour depends on a specific latch
  localparam int LATCH_IF_ID  = 0;
  localparam int LATCH_ID_EX  = 1;
  localparam int LATCH_EX_MEM = 2;
  localparam int LATCH_MEM_WB = 3;

  // control strobes from the stall control to the tag datapath
  typedef struct packed {
    logic                 pcHold;
    logic [NUM_LATCH-1:0] en;
    logic [NUM_LATCH-1:0] bub;
  } ctlStrobes_t;

  // reason the pipeline is not flowing freely this cycle
  typedef enum logic [1:0] {
    CAUSE_NONE,
    CAUSE_IFETCH,
    CAUSE_LOADUSE,
    CAUSE_DMEM
  } stallCause_t;

endpackage

// File: rtl/hazard_detect.sv
module hazard_detect #(
  parameter int REG_ADDR_W = 5,
  parameter int NUM_SRC    = 2
) (
  input  logic                          exLoad,
  input  logic                          exTagValid,
  input  logic [REG_ADDR_W-1:0]         exRd,
  input  logic                          idTagValid,
  input  logic [NUM_SRC*REG_ADDR_W-1:0] idSrcRegs,
  input  logic [NUM_SRC-1:0]            idSrcUsed,
  output logic                          loadUse
);

  logic [NUM_SRC-1:0] srcHit;
  logic               rdLive;

  // register zero is hardwired, a load into it creates no dependency
  assign rdLive = exLoad && exTagValid && (exRd != '0);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign srcHit[k] = idSrcUsed[k] &&
                       (idSrcRegs[k*REG_ADDR_W +: REG_ADDR_W] == exRd);
  end

  assign loadUse = rdLive && idTagValid && (|srcHit);

endmodule

// File: rtl/stall_ctrl.sv
module stall_ctrl
  import pipe_stall_pkg::*;
(
  input  logic        icacheMiss,
  input  logic        dcacheMiss,
  input  logic        loadUse,
  output ctlStrobes_t strobes
);

  stallCause_t cause;

  // priority: data miss freezes everything, then the interlock, then fetch
  always_comb begin
    if (dcacheMiss)      cause = CAUSE_DMEM;
    else if (loadUse)    cause = CAUSE_LOADUSE;
    else if (icacheMiss) cause = CAUSE_IFETCH;
    else                 cause = CAUSE_NONE;
  end

  always_comb begin
    strobes.pcHold = 1'b0;
    strobes.en     = '1;
    strobes.bub    = '0;
    case (cause)
      CAUSE_DMEM: begin
        strobes.pcHold                  = 1'b1;
        strobes.en                      = '0;
        strobes.en[LATCH_MEM_WB]        = 1'b1;
        strobes.bub[LATCH_MEM_WB]       = 1'b1;
      end
      CAUSE_LOADUSE: begin
        strobes.pcHold                  = 1'b1;
        strobes.en[LATCH_IF_ID]         = 1'b0;
        strobes.bub[LATCH_ID_EX]        = 1'b1;
      end
      CAUSE_IFETCH: begin
        strobes.pcHold                  = 1'b1;
        strobes.bub[LATCH_IF_ID]        = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/tag_track.sv
module tag_track #(
  parameter int NUM_LATCH = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LATCH-1:0] en,
  input  logic [NUM_LATCH-1:0] bub,
  output logic [NUM_LATCH-1:0] tags
);

  for (genvar i = 0; i < NUM_LATCH; i++) begin : g_latch
    logic upstream;
    if (i == 0) begin : g_first
      assign upstream = 1'b1;
    end else begin : g_rest
      assign upstream = tags[i-1];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      tags[i] <= 1'b0;
      else if (en[i]) tags[i] <= bub[i] ? 1'b0 : upstream;
    end
  end

endmodule

// File: rtl/perf_counters.sv
module perf_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wbTag,
  output logic [CNT_W-1:0] retired,
  output logic [CNT_W-1:0] bubbles
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retired <= '0;
      bubbles <= '0;
    end else if (wbTag) begin
      retired <= retired + ONE;
    end else begin
      bubbles <= bubbles + ONE;
    end
  end

endmodule

// File: rtl/pipe_interlock_ctrl.sv
module pipe_interlock_ctrl
  import pipe_stall_pkg::*;
#(
  parameter int REG_ADDR_W = 5,
  parameter int NUM_SRC    = 2,
  parameter int CNT_W      = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          icacheMiss,
  input  logic                          dcacheMiss,
  input  logic                          exIsLoad,
  input  logic [REG_ADDR_W-1:0]         exDestReg,
  input  logic [NUM_SRC*REG_ADDR_W-1:0] idSrcRegs,
  input  logic [NUM_SRC-1:0]            idSrcUsed,
  output logic                          pcHold,
  output logic [NUM_LATCH-1:0]          stageEn,
  output logic [NUM_LATCH-1:0]          stageBubble,
  output logic                          idValid,
  output logic                          exValid,
  output logic                          memValid,
  output logic                          wbValid,
  output logic [CNT_W-1:0]              retiredCount,
  output logic [CNT_W-1:0]              bubbleCount
);

  ctlStrobes_t          strobes;
  logic                 loadUse;
  logic [NUM_LATCH-1:0] tags;

  hazard_detect #(
    .REG_ADDR_W(REG_ADDR_W),
    .NUM_SRC   (NUM_SRC)
  ) u_hazard (
    .exLoad    (exIsLoad),
    .exTagValid(tags[LATCH_ID_EX]),
    .exRd      (exDestReg),
    .idTagValid(tags[LATCH_IF_ID]),
    .idSrcRegs (idSrcRegs),
    .idSrcUsed (idSrcUsed),
    .loadUse   (loadUse)
  );

  stall_ctrl u_ctrl (
    .icacheMiss(icacheMiss),
    .dcacheMiss(dcacheMiss),
    .loadUse   (loadUse),
    .strobes   (strobes)
  );

  tag_track #(.NUM_LATCH(NUM_LATCH)) u_tags (
    .clk (clk),
    .rstN(rstN),
    .en  (strobes.en),
    .bub (strobes.bub),
    .tags(tags)
  );

  perf_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rstN   (rstN),
    .wbTag  (tags[LATCH_MEM_WB]),
    .retired(retiredCount),
    .bubbles(bubbleCount)
  );

  assign pcHold      = strobes.pcHold;
  assign stageEn     = strobes.en;
  assign stageBubble = strobes.bub;
  assign idValid     = tags[LATCH_IF_ID];
  assign exValid     = tags[LATCH_ID_EX];
  assign memValid    = tags[LATCH_EX_MEM];
  assign wbValid     = tags[LATCH_MEM_WB];

endmodule

// File: rtl/pipe_interlock_ctrl_chk.sv
module pipe_interlock_ctrl_chk #(
  parameter int REG_ADDR_W = 5,
  parameter int CNT_W      = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  icacheMiss,
  input logic                  dcacheMiss,
  input logic [REG_ADDR_W-1:0] exDestReg,
  input logic                  pcHold,
  input logic [3:0]            stageEn,
  input logic [3:0]            stageBubble,
  input logic                  exValid,
  input logic                  wbValid,
  input logic [CNT_W-1:0]      retiredCount,
  input logic [CNT_W-1:0]      bubbleCount
);

  logic [CNT_W-1:0] countSum;
  assign countSum = retiredCount + bubbleCount;

  AST_DMISS_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    dcacheMiss |-> (pcHold && stageEn == 4'b1000 && stageBubble == 4'b1000)); // R3

  AST_WB_GETS_BUBBLE: assert property (@(posedge clk) disable iff (!rstN)
    stageBubble[3] |=> !wbValid); // R3

  AST_IMISS_INJECT: assert property (@(posedge clk) disable iff (!rstN)
    (icacheMiss && !dcacheMiss && !stageBubble[1]) |->
      (pcHold && stageEn == 4'b1111 && stageBubble == 4'b0001)); // R2

  AST_LOADUSE_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (stageBubble[1] && !dcacheMiss) |->
      (pcHold && !stageEn[0] && stageEn[3:1] == 3'b111)); // R4

  AST_ZERO_DEST_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (exDestReg == '0 && !icacheMiss && !dcacheMiss) |-> !pcHold); // R5

  AST_EX_HELD_TAG: assert property (@(posedge clk) disable iff (!rstN)
    !stageEn[1] |=> (exValid == $past(exValid))); // R7

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (countSum == $past(countSum) + CNT_W'(1))); // R8

  AST_FREE_FLOW: assert property (@(posedge clk) disable iff (!rstN)
    !pcHold |-> (stageEn == 4'b1111 && stageBubble == 4'b0000)); // R10

endmodule

bind pipe_interlock_ctrl pipe_interlock_ctrl_chk #(
  .REG_ADDR_W(REG_ADDR_W),
  .CNT_W     (CNT_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .icacheMiss  (icacheMiss),
  .dcacheMiss  (dcacheMiss),
  .exDestReg   (exDestReg),
  .pcHold      (pcHold),
  .stageEn     (stageEn),
  .stageBubble (stageBubble),
  .exValid     (exValid),
  .wbValid     (wbValid),
  .retiredCount(retiredCount),
  .bubbleCount (bubbleCount)
);

// File: tb/pipe_interlock_ctrl_tb.sv
`timescale 1ns/1ps
module pipe_interlock_ctrl_tb;

  localparam int RW = 2;
  localparam int NS = 2;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          icacheMiss = 1'b0;
  logic          dcacheMiss = 1'b0;
  logic          exIsLoad = 1'b0;
  logic [RW-1:0] exDestReg = '0;
  logic [NS*RW-1:0] idSrcRegs = '0;
  logic [NS-1:0] idSrcUsed = '0;
  logic          pcHold;
  logic [3:0]    stageEn;
  logic [3:0]    stageBubble;
  logic          idValid, exValid, memValid, wbValid;
  logic [CW-1:0] retiredCount, bubbleCount;

  int checks = 0;
  int fails = 0;
  int edges = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) if (rstN) edges <= edges + 1;

  pipe_interlock_ctrl #(.REG_ADDR_W(RW), .NUM_SRC(NS), .CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .icacheMiss(icacheMiss), .dcacheMiss(dcacheMiss),
    .exIsLoad(exIsLoad), .exDestReg(exDestReg), .idSrcRegs(idSrcRegs),
    .idSrcUsed(idSrcUsed), .pcHold(pcHold), .stageEn(stageEn),
    .stageBubble(stageBubble), .idValid(idValid), .exValid(exValid),
    .memValid(memValid), .wbValid(wbValid), .retiredCount(retiredCount),
    .bubbleCount(bubbleCount)
  );

  task automatic check(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    icacheMiss = 1'b0; dcacheMiss = 1'b0; exIsLoad = 1'b0;
    exDestReg = '0; idSrcRegs = '0; idSrcUsed = '0;
  endtask

  task automatic hazardIn();
    exIsLoad = 1'b1; exDestReg = 2'd1; idSrcRegs = {2'd0, 2'd1}; idSrcUsed = 2'b01;
  endtask

  function automatic longint strb();
    return {pcHold, stageEn, stageBubble};
  endfunction

  localparam longint FREE    = {1'b0, 4'b1111, 4'b0000};
  localparam longint LU      = {1'b1, 4'b1110, 4'b0010};
  localparam longint IMISS   = {1'b1, 4'b1111, 4'b0001};
  localparam longint DMISS   = {1'b1, 4'b1000, 4'b1000};

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    longint b0, r0, e0;
    int hz;
    idle();
    tick(); tick();
    #0.5;
    check("R1 retired in reset", retiredCount, 0);
    check("R1 bubbles in reset", bubbleCount, 0);
    check("R1 tags in reset", {idValid, exValid, memValid, wbValid}, 0);
    rstN = 1'b1;
    #0.5;
    check("R1 bubbles at release", bubbleCount, 0);
    repeat (6) tick();
    #0.5;
    check("R8 fill bubbles", bubbleCount, 4);
    check("R8 fill retired", retiredCount, 2);
    check("R7 tags full", {idValid, exValid, memValid, wbValid}, 4'hF);
    check("R10 free flow strobes", strb(), FREE);

    // exhaustive load-use sweep
    b0 = bubbleCount; r0 = retiredCount; e0 = edges; hz = 0;
    for (int rd = 0; rd < 4; rd++)
      for (int s0 = 0; s0 < 4; s0++)
        for (int s1 = 0; s1 < 4; s1++)
          for (int u = 0; u < 4; u++)
            for (int ld = 0; ld < 2; ld++) begin
              bit e;
              tick();
              exIsLoad = ld[0]; exDestReg = rd[1:0];
              idSrcRegs = {s1[1:0], s0[1:0]}; idSrcUsed = u[1:0];
              e = ld[0] && rd != 0 && ((u[0] && s0 == rd) || (u[1] && s1 == rd));
              #0.5;
              check($sformatf("R4 R5 sweep rd=%0d s0=%0d s1=%0d u=%0d ld=%0d", rd, s0, s1, u, ld),
                    strb(), e ? LU : FREE);
              hz += int'(e);
              tick(); idle();
              tick();
            end
    repeat (4) tick();
    #0.5;
    check("R9 sweep bubble delta", bubbleCount - b0, hz);
    check("R8 sweep retired delta", retiredCount - r0, (edges - e0) - hz);

    // hazard against a bubble already in execute
    tick(); hazardIn();
    #0.5;
    check("R4 hazard with valid EX", strb(), LU);
    tick();
    #0.5;
    check("R7 EX tag after bubble", exValid, 0);
    check("R7 ID tag held", idValid, 1);
    check("R4 no hazard on bubble in EX", strb(), FREE);
    tick(); idle(); tick(); tick();

    // instruction cache miss for three cycles
    repeat (4) tick();
    b0 = bubbleCount;
    idle(); icacheMiss = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #0.5;
      check($sformatf("R2 imiss strobes cycle %0d", k), strb(), IMISS);
      if (k > 0) check("R2 ID bubble tag", idValid, 0);
      check("R2 later stages drain", memValid, 1);
      tick();
    end
    idle();
    #0.5;
    check("R10 after imiss", strb(), FREE);
    repeat (5) tick();
    #0.5;
    check("R9 imiss bubble delta", bubbleCount - b0, 3);

    // data cache miss with a load-use hazard present
    b0 = bubbleCount;
    dcacheMiss = 1'b1; hazardIn();
    for (int k = 0; k < 5; k++) begin
      #0.5;
      check($sformatf("R6 R3 dmiss strobes cycle %0d", k), strb(), DMISS);
      if (k > 0) begin
        check("R3 front tags held", {idValid, exValid, memValid}, 3'b111);
        check("R3 WB bubble", wbValid, 0);
      end
      tick();
    end
    idle();
    #0.5;
    check("R10 after dmiss", strb(), FREE);
    repeat (5) tick();
    #0.5;
    check("R9 dmiss bubble delta", bubbleCount - b0, 5);

    // load-use together with an instruction miss
    b0 = bubbleCount;
    hazardIn(); icacheMiss = 1'b1;
    #0.5;
    check("R6 load-use beats imiss", strb(), LU);
    tick(); idle();
    #0.5;
    check("R6 ID kept its instruction", idValid, 1);
    check("R6 EX bubble", exValid, 0);
    repeat (5) tick();
    #0.5;
    check("R9 combined bubble delta", bubbleCount - b0, 1);
    check("R8 one count per edge", retiredCount + bubbleCount, edges);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule